// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer Bank with Coherent Snapshot Readout

This block holds four independent 32-bit down-counters behind a small word-wide register bus. A single global run bit gates the whole bank, and each channel also has its own run bit. A channel advances only on cycles where the shared counter tick input is high. When a running channel's count reaches zero, the next tick reloads the count from that channel's reload register, adds one to a 32-bit wrap counter and raises a sticky event flag. The flag can drive a per-channel interrupt line through a mask bit.

The live count is never presented on the bus directly. Software first reads a channel's wrap-count register. In that same cycle the live count is copied into a shadow. A later read of the current-value register returns the shadow, so the two values software gets describe the same instant. All other registers read back their stored state. Read data is registered and appears on the cycle after the read strobe.

Top module: `timer_bank`

## Requirements
- R1: After reset: the global run bit, all channel run bits, masks, event flags, counts, wrap counts, shadows, read data and interrupt lines are 0, and every reload register reads 0xFFFFFFFF.
- R2: The address map is as follows. The global control register is at 0x00, with the run bit in bit 0. A read-only revision register is at 0x10 and returns the REV_ID parameter. Channel n (0..3) occupies 0x20*(n+1) plus a register offset: 0x00 run (bit 0), 0x04 reload, 0x08 current (shadow), 0x0C wrap count, 0x10 event flag (bit 0), 0x14 flag clear, 0x18 mask (bit 0). Offset 0x1C, unused global offsets and the clear register all read 0. `bus_rdata` carries the value one cycle after `bus_rd` and is 0 on the cycle after any cycle without a read.
- R3: A channel's count changes only on a cycle where the global run bit, its own run bit and `cnt_tick` are all 1. On such a cycle a nonzero count decreases by exactly one.
- R4: Writing 1 to a channel's run bit while that bit is 0 loads the count with the reload value. Writing the run bit while it is already 1 does not reload the count.
- R5: On a running tick with count 0, the count loads the reload value, the wrap count increases by one, and the event flag is set.
- R6: A read of the current-value register returns the count that was latched by the most recent wrap-count read of that channel. The returned value does not change between wrap-count reads.
- R7: A wrap-count read returns the wrap count as it was before that cycle's update. In the same cycle it latches the count as it was before that cycle's update.
- R8: Writing a value with bit 0 set to the clear register clears the event flag. If a wrap happens in the same cycle, the flag stays set. Writing a value with bit 0 clear has no effect.
- R9: `irq[n]` equals channel n's event flag AND its mask bit, delayed by one register stage. With the mask at 0 the line stays low while the flag still records events.
- R10: Writes to the revision, current-value, wrap-count and unmapped addresses change no state. Any access whose address has bits 1:0 nonzero is ignored and reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_tick | input | 1 | Counter advance enable |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | N_TIMERS | Per-channel interrupt lines |

## Verification
The hardest case to reach from the ports is a wrap-count read that lands on the same cycle as a wrap. The count, wrap count, shadow and flag all move on that edge. Reaching this case needs reload values of 0 to 3 and continuous ticks, so that wraps happen nearly every cycle. Long runs of random reads interleaved with those wraps cover it, and a bench model checks every read. A clear write that coincides with a wrap is reached the same way, using a channel with reload 0 that wraps on every tick.

// File: rtl/timer_bank_pkg.sv
package timer_bank_pkg;

  typedef enum logic [2:0] {
    RI_RUN    = 3'd0,
    RI_RELOAD = 3'd1,
    RI_CURR   = 3'd2,
    RI_WRAPS  = 3'd3,
    RI_FLAG   = 3'd4,
    RI_CLEAR  = 3'd5,
    RI_MASK   = 3'd6,
    RI_NONE   = 3'd7
  } reg_idx_e;

  localparam int WIN_SHIFT = 5;

  localparam logic [2:0] GI_CTRL = 3'd0;
  localparam logic [2:0] GI_REV  = 3'd4;

endpackage

// File: rtl/timer_channel.sv
module timer_channel
  import timer_bank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              glb_run,
  input  logic              tick,
  input  logic              sel,
  input  logic              wr,
  input  logic              rd,
  input  reg_idx_e          idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_val,
  output logic              irq_o
);

  localparam logic [DATA_W-1:0] RELOAD_RST = {DATA_W{1'b1}};

  logic              run_q;
  logic [DATA_W-1:0] reload_q;
  logic [DATA_W-1:0] cnt_q;
  logic [DATA_W-1:0] wraps_q;
  logic [DATA_W-1:0] shadow_q;
  logic              flag_q;
  logic              mask_q;
  logic              irq_q;

  logic wr_run, wr_reload, wr_clear, wr_mask, rd_wraps;
  logic start, active, wrap;

  always_comb begin
    wr_run    = sel && wr && (idx == RI_RUN);
    wr_reload = sel && wr && (idx == RI_RELOAD);
    wr_clear  = sel && wr && (idx == RI_CLEAR);
    wr_mask   = sel && wr && (idx == RI_MASK);
    rd_wraps  = sel && rd && (idx == RI_WRAPS);
    start     = wr_run && wdata[0] && !run_q;
    active    = glb_run && run_q && tick;
    wrap      = active && (cnt_q == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      reload_q <= RELOAD_RST;
      mask_q   <= 1'b0;
    end else begin
      if (wr_run)    run_q    <= wdata[0];
      if (wr_reload) reload_q <= wdata;
      if (wr_mask)   mask_q   <= wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= reload_q;
    end else if (active) begin
      cnt_q <= wrap ? reload_q : cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wraps_q <= '0;
    end else if (wrap) begin
      wraps_q <= wraps_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
    end else if (rd_wraps) begin
      shadow_q <= cnt_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
    end else if (wrap) begin
      flag_q <= 1'b1;
    end else if (wr_clear && wdata[0]) begin
      flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= flag_q & mask_q;
  end

  assign irq_o = irq_q;

  always_comb begin
    rd_val = '0;
    unique case (idx)
      RI_RUN:    rd_val[0] = run_q;
      RI_RELOAD: rd_val    = reload_q;
      RI_CURR:   rd_val    = shadow_q;
      RI_WRAPS:  rd_val    = wraps_q;
      RI_FLAG:   rd_val[0] = flag_q;
      RI_MASK:   rd_val[0] = mask_q;
      default:   rd_val    = '0;
    endcase
  end

  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!active && !start) |=> $stable(cnt_q));

  // R3
  step_down_chk: assert property (@(posedge clk) disable iff (rst)
    (active && !start && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R5
  wrap_reload_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt_q == $past(reload_q)) && (wraps_q == $past(wraps_q) + 1'b1) && flag_q);

  // R6
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_wraps |=> $stable(shadow_q));

  // R9
  mask_block_chk: assert property (@(posedge clk) disable iff (rst)
    !mask_q |=> !irq_o);

endmodule

// File: rtl/timer_addr_decode.sv
module timer_addr_decode
  import timer_bank_pkg::*;
#(
  parameter int              N_TIMERS = 4,
  parameter int              DATA_W   = 32,
  parameter int              ADDR_W   = 8,
  parameter logic [31:0]     REV_ID   = 32'h0000_0103
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [ADDR_W-1:0]              addr,
  input  logic                           wr,
  input  logic                           rd,
  input  logic                           glb_run,
  input  logic [N_TIMERS-1:0][DATA_W-1:0] chan_val,
  output reg_idx_e                       idx,
  output logic [N_TIMERS-1:0]            chan_sel,
  output logic                           ctrl_wr,
  output logic [DATA_W-1:0]              rdata
);

  localparam int SLOT_W = ADDR_W - WIN_SHIFT;

  logic              aligned;
  logic [SLOT_W-1:0] slot;
  logic              glb_sel;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    aligned = (addr[1:0] == 2'b00);
    slot    = addr[ADDR_W-1:WIN_SHIFT];
    idx     = reg_idx_e'(addr[WIN_SHIFT-1:2]);
    glb_sel = aligned && (slot == '0);
    ctrl_wr = wr && glb_sel && (addr[WIN_SHIFT-1:2] == GI_CTRL);
  end

  for (genvar g = 0; g < N_TIMERS; g++) begin : g_sel
    assign chan_sel[g] = aligned && (slot == SLOT_W'(g + 1));
  end

  always_comb begin
    rd_mux = '0;
    if (glb_sel) begin
      if (addr[WIN_SHIFT-1:2] == GI_CTRL) rd_mux[0] = glb_run;
      else if (addr[WIN_SHIFT-1:2] == GI_REV) rd_mux = DATA_W'(REV_ID);
    end else begin
      for (int i = 0; i < N_TIMERS; i++) begin
        if (chan_sel[i]) rd_mux = chan_val[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata_q <= '0;
    else if (rd) rdata_q <= rd_mux;
    else         rdata_q <= '0;
  end

  assign rdata = rdata_q;

  // R2
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rd |=> (rdata == '0));

  // R10
  misaligned_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && addr[1:0] != 2'b00) |=> (rdata == '0));

endmodule

// File: rtl/timer_bank.sv
module timer_bank
  import timer_bank_pkg::*;
#(
  parameter int          N_TIMERS = 4,
  parameter int          DATA_W   = 32,
  parameter int          ADDR_W   = 8,
  parameter logic [31:0] REV_ID   = 32'h0000_0103
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cnt_tick,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [N_TIMERS-1:0] irq
);

  logic                            glb_run_q;
  logic                            ctrl_wr;
  reg_idx_e                        idx;
  logic [N_TIMERS-1:0]             chan_sel;
  logic [N_TIMERS-1:0][DATA_W-1:0] chan_val;

  timer_addr_decode #(
    .N_TIMERS (N_TIMERS),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .REV_ID   (REV_ID)
  ) u_decode (
    .clk      (clk),
    .rst      (rst),
    .addr     (bus_addr),
    .wr       (bus_wr),
    .rd       (bus_rd),
    .glb_run  (glb_run_q),
    .chan_val (chan_val),
    .idx      (idx),
    .chan_sel (chan_sel),
    .ctrl_wr  (ctrl_wr),
    .rdata    (bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst)          glb_run_q <= 1'b0;
    else if (ctrl_wr) glb_run_q <= bus_wdata[0];
  end

  for (genvar g = 0; g < N_TIMERS; g++) begin : g_chan
    timer_channel #(
      .DATA_W (DATA_W)
    ) u_chan (
      .clk     (clk),
      .rst     (rst),
      .glb_run (glb_run_q),
      .tick    (cnt_tick),
      .sel     (chan_sel[g]),
      .wr      (bus_wr),
      .rd      (bus_rd),
      .idx     (idx),
      .wdata   (bus_wdata),
      .rd_val  (chan_val[g]),
      .irq_o   (irq[g])
    );
  end

  // R2
  one_window_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(chan_sel));

  // R9
  irq_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (irq == '0));

endmodule

// File: tb/timer_bank_tb.sv
`timescale 1ns/1ps
module timer_bank_tb;

  localparam int          NT  = 4;
  localparam logic [31:0] REV = 32'h0000_0103;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnt_tick = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq;

  timer_bank #(.N_TIMERS(NT), .DATA_W(32), .ADDR_W(8), .REV_ID(REV)) u_dut (
    .clk(clk), .rst(rst), .cnt_tick(cnt_tick), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  always #10 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int tick_mode = 2;
  string cur_req = "R1";

  // reference model state
  logic        m_gen;
  logic        m_en [NT];
  logic [31:0] m_rel [NT];
  logic [31:0] m_cnt [NT];
  logic [31:0] m_wr [NT];
  logic [31:0] m_sh [NT];
  logic        m_st [NT];
  logic        m_mk [NT];
  logic [31:0] exp_rd = '0;
  logic [3:0]  exp_irq = '0;

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
      finish_run();
    end
  end

  always @(negedge clk) begin
    case (tick_mode)
      0: cnt_tick <= 1'b1;
      1: cnt_tick <= ($urandom % 3) == 0;
      3: cnt_tick <= ($urandom % 4) != 0;
      default: cnt_tick <= 1'b0;
    endcase
  end

  // cycle model
  always @(posedge clk) begin
    int slot, ri, ch;
    logic al, run, wrp;
    logic [31:0] e;
    if (rst) begin
      m_gen = 1'b0;
      for (int i = 0; i < NT; i++) begin
        m_en[i] = 0; m_rel[i] = 32'hFFFF_FFFF; m_cnt[i] = 0; m_wr[i] = 0;
        m_sh[i] = 0; m_st[i] = 0; m_mk[i] = 0;
      end
      exp_rd = '0;
      exp_irq = '0;
    end else begin
      slot = int'(bus_addr >> 5);
      ri   = int'((bus_addr >> 2) & 8'h7);
      al   = (bus_addr[1:0] == 2'b00);
      e = '0;
      if (bus_rd && al) begin
        if (slot == 0) begin
          if (ri == 0) e = {31'b0, m_gen};
          else if (ri == 4) e = REV;
        end else if (slot <= NT) begin
          ch = slot - 1;
          case (ri)
            0: e = {31'b0, m_en[ch]};
            1: e = m_rel[ch];
            2: e = m_sh[ch];
            3: e = m_wr[ch];
            4: e = {31'b0, m_st[ch]};
            6: e = {31'b0, m_mk[ch]};
            default: e = '0;
          endcase
        end
      end
      exp_rd = e;
      for (int i = 0; i < NT; i++) exp_irq[i] = m_st[i] & m_mk[i];
      for (int i = 0; i < NT; i++) begin
        logic acc;
        acc = al && (slot == i + 1);
        run = m_gen && m_en[i] && cnt_tick;
        wrp = run && (m_cnt[i] == 0);
        if (acc && bus_rd && ri == 3) m_sh[i] = m_cnt[i];
        if (acc && bus_wr && ri == 0 && bus_wdata[0] && !m_en[i]) m_cnt[i] = m_rel[i];
        else if (run) m_cnt[i] = wrp ? m_rel[i] : m_cnt[i] - 1;
        if (wrp) m_wr[i] = m_wr[i] + 1;
        if (wrp) m_st[i] = 1'b1;
        else if (acc && bus_wr && ri == 5 && bus_wdata[0]) m_st[i] = 1'b0;
        if (acc && bus_wr) begin
          if (ri == 0) m_en[i] = bus_wdata[0];
          if (ri == 1) m_rel[i] = bus_wdata;
          if (ri == 6) m_mk[i] = bus_wdata[0];
        end
      end
      if (al && bus_wr && slot == 0 && ri == 0) m_gen = bus_wdata[0];
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk(bus_rdata, exp_rd, {cur_req, " read data vs model"});
      chk({28'b0, irq}, {28'b0, exp_irq}, "R9 irq vs model");
    end
  end

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd_exp(input logic [7:0] a, input logic [31:0] e, input string tag);
    bus_read(a);
    #1;
    chk(bus_rdata, e, tag);
  endtask

  function automatic logic [7:0] ca(input int ch, input int ri);
    return 8'(32 * (ch + 1) + 4 * ri);
  endfunction

  task automatic snap(input int ch);
    bus_read(ca(ch, 3));
    bus_read(ca(ch, 2));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk({28'b0, irq}, 32'h0, "R1 irq after reset");
    rd_exp(8'h00, 32'h0, "R1 global run");
    rd_exp(ca(0, 1), 32'hFFFF_FFFF, "R1 reload reset");
    rd_exp(ca(3, 1), 32'hFFFF_FFFF, "R1 reload reset ch3");
    rd_exp(ca(0, 3), 32'h0, "R1 wrap count reset");
    rd_exp(ca(2, 4), 32'h0, "R1 flag reset");
    rd_exp(8'h10, REV, "R2 revision");
    rd_exp(ca(0, 7), 32'h0, "R2 unmapped offset");
    rd_exp(ca(1, 5), 32'h0, "R2 clear reads zero");

    cur_req = "R10";
    bus_write(8'h10, 32'hDEAD_BEEF);
    rd_exp(8'h10, REV, "R10 revision write ignored");
    bus_write(ca(0, 2), 32'h1234);
    bus_write(ca(0, 3), 32'h55);
    rd_exp(ca(0, 3), 32'h0, "R10 wrap write ignored");
    rd_exp(ca(0, 2), 32'h0, "R10 current write ignored");
    bus_write(8'h25, 32'h7);
    rd_exp(ca(0, 1), 32'hFFFF_FFFF, "R10 misaligned write ignored");
    rd_exp(8'h24 | 8'h1, 32'h0, "R10 misaligned read zero");

    cur_req = "R4";
    bus_write(ca(0, 1), 32'd5);
    bus_write(ca(0, 0), 32'd1);
    snap(0);
    #1 chk(bus_rdata, 32'd5, "R4 start loads reload");

    cur_req = "R3";
    tick_mode = 0;
    repeat (10) @(negedge clk);
    snap(0);
    #1 chk(bus_rdata, 32'd5, "R3 global off holds count");
    bus_write(8'h00, 32'd1);
    repeat (7) snap(0);
    tick_mode = 1;
    repeat (10) snap(0);

    cur_req = "R5";
    tick_mode = 0;
    bus_write(ca(1, 1), 32'd2);
    bus_write(ca(1, 6), 32'd1);
    bus_write(ca(1, 0), 32'd1);
    repeat (12) begin snap(1); bus_read(ca(1, 4)); end

    cur_req = "R6";
    bus_read(ca(1, 3));
    repeat (6) bus_read(ca(1, 2));

    cur_req = "R7";
    repeat (8) bus_read(ca(1, 3));

    cur_req = "R8";
    bus_write(ca(2, 1), 32'd0);
    bus_write(ca(2, 6), 32'd1);
    bus_write(ca(2, 0), 32'd1);
    bus_write(ca(2, 5), 32'd1);
    bus_read(ca(2, 4));
    tick_mode = 2;
    repeat (2) @(negedge clk);
    bus_write(ca(2, 5), 32'd0);
    rd_exp(ca(2, 4), 32'd1, "R8 clear with bit0 low ignored");
    bus_write(ca(2, 5), 32'd1);
    rd_exp(ca(2, 4), 32'd0, "R8 clear");

    cur_req = "R9";
    bus_write(ca(3, 1), 32'd1);
    bus_write(ca(3, 0), 32'd1);
    tick_mode = 0;
    repeat (6) @(negedge clk);
    #1 chk({31'b0, irq[3]}, 32'd0, "R9 mask zero blocks irq");
    rd_exp(ca(3, 4), 32'd1, "R9 flag records while masked");
    bus_write(ca(3, 6), 32'd1);
    repeat (3) @(negedge clk);
    #1 chk({31'b0, irq[3]}, 32'd1, "R9 irq with mask");

    cur_req = "R4";
    bus_write(ca(0, 1), 32'd9);
    bus_write(ca(0, 0), 32'd1);
    snap(0);
    bus_write(ca(0, 0), 32'd0);
    bus_write(ca(0, 0), 32'd1);
    snap(0);

    cur_req = "R2";
    tick_mode = 3;
    for (int k = 0; k < 4000; k++) begin
      int op, ch, ri;
      logic [7:0] a;
      op = int'($urandom % 16);
      ch = int'($urandom % 4);
      ri = int'($urandom % 8);
      a = ca(ch, ri);
      if (op == 0) a = 8'(($urandom % 2) * 16);
      if (op == 1) a = a | 8'($urandom % 4);
      if (op < 5) begin
        case (ri)
          1: bus_write(a, $urandom % 4);
          0, 6: bus_write(a, ($urandom % 4) != 0 ? 32'd1 : 32'd0);
          default: bus_write(a, $urandom);
        endcase
        if (op == 0) bus_write(8'h00, ($urandom % 8) != 0 ? 32'd1 : 32'd0);
      end else if (op < 9) begin
        snap(ch);
      end else begin
        bus_read(a);
      end
    end

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule